// File: doc/BRIEF.md
# Audio Codec Control Registers and Zero Flag

This block is the control plane of a multichannel audio codec. A host writes and reads three 8-bit control registers through a parallel strobe port that carries a command code and a data byte. From the stored bits the block drives the power-management, internal-run, soft-mute and serial-format levels. It also gates the clock and serial-data output pins, which are forced low when disabled.

The block also folds the zero-detect indications of the DACs into one flag pin. Each DAC can be masked out of the flag. A polarity bit picks the active level. While the internal timing is held in reset, the flag is forced to its active state. The DAC datapaths and the zero detectors lie outside the block and only their indications come in.

Top module: `codec_ctl_top`

## Requirements
- R1: After reset, command 01h reads 0x07, command 02h reads 0x08 and command 03h reads 0x00.
- R2: A read strobe presents the addressed register on rd_data at the next rising edge. Writes change only the writable bits: mask 0x07 for 01h, 0xF9 for 02h and 0xFE for 03h. All other bits read 0, so writing 0xFF reads back 0x07, 0xF9 and 0xFE.
- R3: Any command code other than 01h, 02h and 03h reads back 0x00, and a write to it leaves all three registers unchanged.
- R4: adc_pwr_on follows bit 2 of 01h, dac_pwr_on follows bit 1 of 01h, and core_run follows bit 0 of 01h.
- R5: fmt_i2s follows bit 3 of 02h (1 = I2S, 0 = left-justified). dac_quiet is 1 when bit 1 of 01h is 0 or bit 0 of 02h (soft mute) is 1.
- R6: Bits 5, 6 and 7 of 02h mask DAC1, DAC2 and DAC3 (dac_zero[0], [1], [2]) when 1. The flag is active when at least one DAC is unmasked and every unmasked DAC reports zero.
- R7: Bit 4 of 02h selects the flag polarity. With 0, active is high and inactive is low. With 1, active is low and inactive is high.
- R8: With all three DACs masked and core_run at 1, the flag stays inactive whatever dac_zero holds.
- R9: While bit 0 of 01h is 0, the flag is active regardless of the DAC inputs and masks, and the other register contents are kept.
- R10: Each output pin is gated by one bit of 03h: lrck_out by bit 7, bick_out by bit 6, clko_out by bit 5, sd_out[2] by bit 3, sd_out[1] by bit 2 and sd_out[0] by bit 1. A pin drives its input when its bit is 1 and drives 0 otherwise. Bit 4 is stored and read back but gates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per access |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 8 | Command code |
| cmd_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, updated the cycle after a read strobe |
| adc_pwr_on | output | 1 | ADC power enable |
| dac_pwr_on | output | 1 | DAC power enable |
| core_run | output | 1 | Internal timing running (0 = held in reset) |
| fmt_i2s | output | 1 | Serial format select |
| dac_quiet | output | 1 | DAC powered down or soft-muted |
| dac_zero | input | 3 | Zero indications, bit 0 = DAC1 |
| zflag_out | output | 1 | Combined zero flag pin |
| lrck_in | input | 1 | Frame clock to be gated |
| bick_in | input | 1 | Bit clock to be gated |
| mclk_in | input | 1 | Master clock to be gated |
| sd_in | input | 3 | Serial data lanes to be gated |
| lrck_out | output | 1 | Gated frame clock |
| bick_out | output | 1 | Gated bit clock |
| clko_out | output | 1 | Gated master clock |
| sd_out | output | 3 | Gated serial data lanes |

## Verification
The zero flag is tried with every mask combination class. Under no mask, a single nonzero DAC must clear the flag, which separates the AND across DACs from an OR. Under partial masks, a nonzero masked DAC must not matter while a nonzero unmasked one must. With all DACs masked, the case that separates "no unmasked DAC" from "all unmasked zero" is exercised. Each case runs under both polarities and again with the internal reset held, which shows that the forced state overrides masks and that the other registers survive. The pin gates are driven with all inputs high under enables that differ per pin, and with only the reserved bit set, so a swapped or misplaced enable bit shows up as a wrong pin level.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_REGS = 3;
  localparam int NUM_DAC  = 3;
  localparam int NUM_SD   = 3;
  localparam logic [7:0] ADDR_BASE = 8'h01;

  // field positions that the top decodes
  localparam int PWR_ADC_B = 2;
  localparam int PWR_DAC_B = 1;
  localparam int RUN_B     = 0;
  localparam int MASK_LO_B = 5;
  localparam int POL_B     = 4;
  localparam int FMT_B     = 3;
  localparam int MUTE_B    = 0;

  function automatic logic [REG_W-1:0] reg_reset(input int idx);
    case (idx)
      0:       return 8'h07;
      1:       return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] reg_wmask(input int idx);
    case (idx)
      0:       return 8'h07;
      1:       return 8'hF9;
      default: return 8'hFE;
    endcase
  endfunction

  function automatic logic [7:0] reg_addr(input int idx);
    return ADDR_BASE + 8'(idx);
  endfunction

  // flag is active when some DAC is unmasked and all unmasked DACs are zero
  function automatic logic zero_all(input logic [NUM_DAC-1:0] zero,
                                    input logic [NUM_DAC-1:0] ignore);
    return (|(~ignore)) & (&(zero | ignore));
  endfunction
endpackage

// File: rtl/codec_ctl_regs.sv
module codec_ctl_regs
  import codec_ctl_pkg::*;
#(
  parameter int W = REG_W,
  parameter int N = NUM_REGS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic               cmd_write,
  input  logic [7:0]         cmd_addr,
  input  logic [W-1:0]       cmd_wdata,
  output logic [W-1:0]       rd_data,
  output logic [N-1:0][W-1:0] q
);
  logic [N-1:0] wr_hit;
  logic [N-1:0] addr_hit;
  logic         known;
  logic [W-1:0] rd_sel;

  for (genvar i = 0; i < N; i++) begin : g_reg
    localparam logic [W-1:0] RST = reg_reset(i);
    localparam logic [W-1:0] WM  = reg_wmask(i);
    assign addr_hit[i] = (cmd_addr == reg_addr(i));
    assign wr_hit[i]   = cmd_valid & cmd_write & addr_hit[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q[i] <= RST;
      else if (wr_hit[i]) q[i] <= (q[i] & ~WM) | (cmd_wdata & WM);
    end

    // R3: a register without a write strobe keeps its value
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_hit[i]) |-> $stable(q[i]));
    // R2: read-only bits stay zero
    a_r2_ro_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (q[i] & ~WM) == '0);
  end

  assign known = |addr_hit;

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < N; i++)
      if (addr_hit[i]) rd_sel = q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rd_data <= '0;
    else if (cmd_valid && !cmd_write) rd_data <= rd_sel;
  end

  // R3: unknown command reads back zero
  a_r3_unknown_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write && !known) |=> rd_data == '0);
endmodule

// File: rtl/codec_zflag.sv
module codec_zflag
  import codec_ctl_pkg::*;
#(
  parameter int ND = NUM_DAC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [ND-1:0] zero_in,
  input  logic [ND-1:0] ignore,
  input  logic          low_active,
  input  logic          run,
  output logic          flag
);
  logic active;

  assign active = !run | zero_all(zero_in, ignore);
  assign flag   = active ^ low_active;

  // R9: internal reset forces the active level
  a_r9_reset_forces: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> flag == !low_active);
  // R8: everything masked keeps the inactive level
  a_r8_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (&ignore)) |-> flag == low_active);
  // R6: one unmasked nonzero DAC keeps the flag inactive
  a_r6_nonzero_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (run && |(~ignore & ~zero_in)) |-> flag == low_active);
endmodule

// File: rtl/codec_pin_gate.sv
module codec_pin_gate #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] en,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pin_out[i] = pin_in[i] & en[i];
    // R10: a disabled pin drives low
    a_r10_off_low: assert property (@(posedge clk) disable iff (!rst_n)
      !en[i] |-> !pin_out[i]);
  end
endmodule

// File: rtl/codec_ctl_top.sv
module codec_ctl_top
  import codec_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic               cmd_write,
  input  logic [7:0]         cmd_addr,
  input  logic [REG_W-1:0]   cmd_wdata,
  output logic [REG_W-1:0]   rd_data,
  output logic               adc_pwr_on,
  output logic               dac_pwr_on,
  output logic               core_run,
  output logic               fmt_i2s,
  output logic               dac_quiet,
  input  logic [NUM_DAC-1:0] dac_zero,
  output logic               zflag_out,
  input  logic               lrck_in,
  input  logic               bick_in,
  input  logic               mclk_in,
  input  logic [NUM_SD-1:0]  sd_in,
  output logic               lrck_out,
  output logic               bick_out,
  output logic               clko_out,
  output logic [NUM_SD-1:0]  sd_out
);
  localparam int GW = NUM_SD + 3;

  logic [NUM_REGS-1:0][REG_W-1:0] q;
  logic [REG_W-1:0] r_pwr, r_fmt, r_pin;
  logic [GW-1:0] gate_en, gate_in, gate_out;
  logic unused_bits;

  codec_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rd_data(rd_data), .q(q)
  );

  assign r_pwr = q[0];
  assign r_fmt = q[1];
  assign r_pin = q[2];

  assign adc_pwr_on = r_pwr[PWR_ADC_B];
  assign dac_pwr_on = r_pwr[PWR_DAC_B];
  assign core_run   = r_pwr[RUN_B];
  assign fmt_i2s    = r_fmt[FMT_B];
  assign dac_quiet  = !r_pwr[PWR_DAC_B] | r_fmt[MUTE_B];

  codec_zflag u_zflag (
    .clk(clk), .rst_n(rst_n), .zero_in(dac_zero),
    .ignore(r_fmt[MASK_LO_B +: NUM_DAC]), .low_active(r_fmt[POL_B]),
    .run(r_pwr[RUN_B]), .flag(zflag_out)
  );

  // enables: clocks in bits 7..5, lanes in bits 3..1; bit 4 is stored only
  assign gate_en = {r_pin[7:5], r_pin[NUM_SD:1]};
  assign gate_in = {lrck_in, bick_in, mclk_in, sd_in};

  codec_pin_gate #(.W(GW)) u_gate (
    .clk(clk), .rst_n(rst_n), .en(gate_en), .pin_in(gate_in), .pin_out(gate_out)
  );

  assign {lrck_out, bick_out, clko_out, sd_out} = gate_out;
  assign unused_bits = ^{r_pwr[7:3], r_fmt[2:1], r_pin[4], r_pin[0]};

  // R5: quiet level tracks power-down or soft mute
  a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (r_fmt[MUTE_B] || !dac_pwr_on) |-> dac_quiet);
  // R4: a write to 01h shows on the power levels the next cycle
  a_r4_pwr: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write && cmd_addr == 8'h01) |=>
      {adc_pwr_on, dac_pwr_on, core_run} == $past(cmd_wdata[2:0]));
endmodule

// File: tb/sim_codec_ctl_top.sv
`timescale 1ns/1ps
module sim_codec_ctl_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [7:0] cmd_addr = '0, cmd_wdata = '0, rd_data;
  logic adc_pwr_on, dac_pwr_on, core_run, fmt_i2s, dac_quiet, zflag_out;
  logic [2:0] dac_zero = '0, sd_in = '0, sd_out;
  logic lrck_in = 1'b0, bick_in = 1'b0, mclk_in = 1'b0;
  logic lrck_out, bick_out, clko_out;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  codec_ctl_top u0 (.*);

  // {reg02 value, dac_zero, expected flag}
  localparam logic [11:0] VEC [12] = '{
    {8'h08, 3'b111, 1'b1}, {8'h08, 3'b011, 1'b0}, {8'h08, 3'b000, 1'b0},
    {8'h88, 3'b011, 1'b1}, {8'h88, 3'b101, 1'b0}, {8'hC8, 3'b001, 1'b1},
    {8'hE8, 3'b111, 1'b0}, {8'h18, 3'b111, 1'b0}, {8'h18, 3'b110, 1'b1},
    {8'hF8, 3'b111, 1'b1}, {8'h28, 3'b110, 1'b1}, {8'h48, 3'b010, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    d = rd_data;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(8'h01, v); chk("R1 reg01 reset", v, 8'h07);
    rd(8'h02, v); chk("R1 reg02 reset", v, 8'h08);
    rd(8'h03, v); chk("R1 reg03 reset", v, 8'h00);
    chk("R4 power levels at reset", {adc_pwr_on, dac_pwr_on, core_run}, 3'b111);
    chk("R5 fmt at reset", fmt_i2s, 1'b1);
    chk("R5 quiet at reset", dac_quiet, 1'b0);

    for (int i = 0; i < 12; i++) begin
      wr(8'h02, VEC[i][11:4]);
      dac_zero = VEC[i][3:1];
      #1;
      chk($sformatf("R6/R7/R8 vector %0d", i), zflag_out, VEC[i][0]);
    end

    wr(8'h01, 8'hFF); rd(8'h01, v); chk("R2 reg01 ro bits", v, 8'h07);
    wr(8'h02, 8'hFF); rd(8'h02, v); chk("R2 reg02 ro bits", v, 8'hF9);
    wr(8'h03, 8'hFF); rd(8'h03, v); chk("R2 reg03 ro bits", v, 8'hFE);

    wr(8'h04, 8'hFF); rd(8'h04, v); chk("R3 unknown reads zero", v, 8'h00);
    wr(8'h00, 8'h00); rd(8'h00, v); chk("R3 code 00 reads zero", v, 8'h00);
    rd(8'h01, v); chk("R3 reg01 untouched", v, 8'h07);
    rd(8'h02, v); chk("R3 reg02 untouched", v, 8'hF9);
    rd(8'h03, v); chk("R3 reg03 untouched", v, 8'hFE);

    wr(8'h01, 8'h05);
    chk("R4 dac power off", {adc_pwr_on, dac_pwr_on, core_run}, 3'b101);
    chk("R5 quiet on power down", dac_quiet, 1'b1);
    wr(8'h01, 8'h07); wr(8'h02, 8'h01);
    chk("R5 quiet on soft mute", dac_quiet, 1'b1);
    chk("R5 left-justified", fmt_i2s, 1'b0);
    wr(8'h02, 8'h08);
    chk("R5 quiet released", dac_quiet, 1'b0);

    // internal reset forces active level, even with all masked or nonzero
    wr(8'h02, 8'hE8); dac_zero = 3'b000;
    wr(8'h01, 8'h06);
    chk("R9 forced active high", zflag_out, 1'b1);
    chk("R4 core_run low", core_run, 1'b0);
    wr(8'h02, 8'h18);
    chk("R9 forced active low", zflag_out, 1'b0);
    rd(8'h02, v); chk("R9 reg02 kept", v, 8'h18);
    wr(8'h01, 8'h07);
    chk("R9 released inactive", zflag_out, 1'b1);

    lrck_in = 1'b1; bick_in = 1'b1; mclk_in = 1'b1; sd_in = 3'b111;
    wr(8'h03, 8'h00);
    chk("R10 all gated low", {lrck_out, bick_out, clko_out, sd_out}, 6'b000000);
    wr(8'h03, 8'h10);
    chk("R10 reserved no effect", {lrck_out, bick_out, clko_out, sd_out}, 6'b000000);
    rd(8'h03, v); chk("R10 reserved stored", v, 8'h10);
    wr(8'h03, 8'hA4);
    chk("R10 mixed enables", {lrck_out, bick_out, clko_out, sd_out}, 6'b101010);
    wr(8'h03, 8'h4A);
    chk("R10 other enables", {lrck_out, bick_out, clko_out, sd_out}, 6'b010101);
    sd_in = 3'b000;
    #1;
    chk("R10 lanes follow input", sd_out, 3'b000);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule